// File: doc/BRIEF.md
# Timer Compare/Capture Channel

One channel of a general-purpose timer. A free-running up counter advances on every clock while its run input is high and holds while it is low. One general register works next to it, and its role comes from a 4-bit control field.

As a compare register, the general register drives an output pin. While the counter is stopped, the pin is held at an idle level. When the running counter equals the register, the pin goes low, goes high or toggles. As a capture register, the general register loads the counter value in one of two cases: on the selected edges of a synchronized input pin, or on a count-event strobe that comes from a neighbouring counter.

A buffer-mode input takes the register out of both roles. It then only keeps what software writes, and the pin function is turned off. Software writes the control field and the general register through two write strobes. The control field reads back zero-extended to 8 bits.

Top module: `tmr_chan_ctl`

## Requirements
- R1: After reset the counter `cnt_q` is 0. It increments by one on each clock edge that samples `cnt_run` high, wrapping at 2^CNT_W. It holds its value on any edge that samples `cnt_run` low.
- R2: `ctl_q` resets to 0. Bits 3:0 of `ctl_q` show the last value written with `ctl_we`. Bits 7:4 always read 0.
- R3: Control codes 0000 and 0100 keep `pin_oe` at 0. With these codes a compare match leaves `pin_out` unchanged.
- R4: Codes 0001, 0010 and 0011 give an idle level of 0 and `pin_oe` = 1. On a compare match the pin goes to 0, goes to 1 or toggles, respectively.
- R5: Codes 0101, 0110 and 0111 give an idle level of 1 and `pin_oe` = 1. On a compare match the pin goes to 0, goes to 1 or toggles, respectively.
- R6: The idle level of an output code is loaded into `pin_out` on each edge that samples `cnt_run` low. While the counter runs, a new control code changes `pin_out` only through compare matches.
- R7: A compare match is a cycle with `cnt_run` high and `cnt_q` equal to `gr_q`. The pin action appears on the clock edge that ends that cycle.
- R8: `cap_pin` passes through SYNC_STAGES flip-flops before edge detection. Code 1000 captures on rising edges, 1001 on falling edges, and 1010/1011 on both. `gr_q` takes the `cnt_q` value that is present SYNC_STAGES edges after the edge that first samples the new pin level, and it loads on the edge that follows.
- R9: Codes 11xx load `cnt_q` into `gr_q` on the edge that samples `cnt_evt` high. Pin edges then cause no capture.
- R10: While `buf_mode` is high, the control code has no effect. `pin_oe` is 0, `pin_out` holds its value, and `gr_q` changes only through `gr_we`.
- R11: When a capture and a `gr_we` write fall in the same cycle, the captured counter value is stored and the write data is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_run | input | 1 | Counter run bit |
| buf_mode | input | 1 | Puts the general register into plain buffer use |
| ctl_we | input | 1 | Control field write strobe |
| ctl_wdata | input | 4 | Control field write data |
| gr_we | input | 1 | General register write strobe |
| gr_wdata | input | CNT_W | General register write data |
| cap_pin | input | 1 | Asynchronous capture input pin |
| cnt_evt | input | 1 | Count-event strobe from neighbouring counter |
| ctl_q | output | 8 | Control field readback, upper bits zero |
| gr_q | output | CNT_W | General register |
| cnt_q | output | CNT_W | Counter value |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin enable |

## Verification
A register write is visible at the sample point after the edge that took it. The idle level appears one edge later still. A compare match is seen at the sample point where `cnt_q` equals the register, and the new pin level appears at the sample point after that, so each check first confirms the old level in the match cycle. A pin capture lands three edges after the pin changes: the bench records `cnt_q` at the sample point after the second edge and expects exactly that value in `gr_q` after the third. Strobe captures and same-cycle write conflicts are checked one edge after the strobe. All checks sample on the falling clock edge.

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_run,
  input  logic             buf_mode,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wdata,
  input  logic             gr_we,
  input  logic [CNT_W-1:0] gr_wdata,
  input  logic             cap_pin,
  input  logic             cnt_evt,
  output logic [7:0]       ctl_q,
  output logic [CNT_W-1:0] gr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pin_out,
  output logic             pin_oe
);

  logic [3:0]           code;
  logic [SYNC_STAGES:0] cap_sh;
  logic                 pin_lvl;

  wire is_out   = !buf_mode && !code[3] && (code[1:0] != 2'b00);
  wire is_cap   = !buf_mode && code[3];
  wire hit      = cnt_run && (cnt_q == gr_q);
  wire cap_now  = cap_sh[SYNC_STAGES-1];
  wire cap_old  = cap_sh[SYNC_STAGES];
  wire rise     = cap_now && !cap_old;
  wire fall     = !cap_now && cap_old;

  logic trig;
  always_comb begin
    unique casez (code[2:0])
      3'b1??:  trig = cnt_evt;
      3'b01?:  trig = rise || fall;
      3'b001:  trig = fall;
      default: trig = rise;
    endcase
  end

  wire cap_hit = is_cap && trig;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_run) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code <= 4'b0000;
    else if (ctl_we) code <= ctl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cap_sh <= '0;
    else cap_sh <= {cap_sh[SYNC_STAGES-1:0], cap_pin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gr_q <= '0;
    else if (cap_hit) gr_q <= cnt_q;
    else if (gr_we) gr_q <= gr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_lvl <= 1'b0;
    else if (is_out) begin
      if (!cnt_run) pin_lvl <= code[2];
      else if (hit) begin
        unique case (code[1:0])
          2'b01:   pin_lvl <= 1'b0;
          2'b10:   pin_lvl <= 1'b1;
          default: pin_lvl <= !pin_lvl;
        endcase
      end
    end
  end

  assign ctl_q   = {4'b0000, code};
  assign pin_out = pin_lvl;
  assign pin_oe  = is_out;

endmodule

module tmr_chan_ctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_run,
  input logic             buf_mode,
  input logic             gr_we,
  input logic             cnt_evt,
  input logic [7:0]       ctl_q,
  input logic [CNT_W-1:0] gr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             pin_out,
  input logic             pin_oe
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_run |=> cnt_q == ($past(cnt_q) + 1'b1)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_run |=> $stable(cnt_q)); // R1

  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7:4] == 4'b0000); // R2

  AST_OFF_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[3:0] == 4'b0000 || ctl_q[3:0] == 4'b0100) |-> !pin_oe); // R3

  AST_SET_HIGH_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_mode && ctl_q[3:0] == 4'b0010 && cnt_run && cnt_q == gr_q) |=> pin_out); // R4

  AST_SET_LOW_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_mode && ctl_q[3:0] == 4'b0101 && cnt_run && cnt_q == gr_q) |=> !pin_out); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_mode && !cnt_run && !ctl_q[3] && ctl_q[1:0] != 2'b00) |=> pin_out == $past(ctl_q[2])); // R6

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_mode && ctl_q[3:2] == 2'b11 && cnt_evt) |=> gr_q == $past(cnt_q)); // R9

  AST_BUF_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |-> !pin_oe); // R10

  AST_BUF_GR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !gr_we) |=> $stable(gr_q)); // R10

  AST_BUF_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |=> $stable(pin_out)); // R10

endmodule

bind tmr_chan_ctl tmr_chan_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .buf_mode(buf_mode),
  .gr_we(gr_we), .cnt_evt(cnt_evt), .ctl_q(ctl_q), .gr_q(gr_q),
  .cnt_q(cnt_q), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_tmr_chan_ctl.sv
`timescale 1ns/1ps
module test_tmr_chan_ctl;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n, cnt_run, buf_mode, ctl_we, gr_we, cap_pin, cnt_evt;
  logic [3:0]   ctl_wdata;
  logic [W-1:0] gr_wdata;
  logic [7:0]   ctl_q;
  logic [W-1:0] gr_q, cnt_q;
  logic         pin_out, pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_chan_ctl #(.CNT_W(W), .SYNC_STAGES(2)) i_tmr_chan_ctl (
    .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .buf_mode(buf_mode),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .gr_we(gr_we), .gr_wdata(gr_wdata),
    .cap_pin(cap_pin), .cnt_evt(cnt_evt), .ctl_q(ctl_q), .gr_q(gr_q),
    .cnt_q(cnt_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cnt_run = 0; buf_mode = 0; ctl_we = 0; gr_we = 0;
    cap_pin = 0; cnt_evt = 0; ctl_wdata = '0; gr_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put_ctl(input logic [3:0] c);
    ctl_we = 1; ctl_wdata = c;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic put_gr(input logic [W-1:0] d);
    gr_we = 1; gr_wdata = d;
    @(negedge clk);
    gr_we = 0;
  endtask

  task automatic t_reset_ctl();
    do_reset();
    check("R1 reset cnt", 32'(cnt_q), 0);
    check("R2 reset ctl", 32'(ctl_q), 0);
    check("R3 reset oe", 32'(pin_oe), 0);
    put_ctl(4'hB);
    check("R2 readback", 32'(ctl_q), 32'h0B);
    put_ctl(4'hF);
    check("R2 upper zero", 32'(ctl_q), 32'h0F);
  endtask

  task automatic t_count();
    do_reset();
    cnt_run = 1;
    repeat (10) @(negedge clk);
    check("R1 run count", 32'(cnt_q), 10);
    cnt_run = 0;
    repeat (3) @(negedge clk);
    check("R1 hold", 32'(cnt_q), 10);
  endtask

  task automatic t_cmp(input logic [3:0] c, input logic init, input logic fin, input string req);
    do_reset();
    put_gr(16'd4);
    put_ctl(c);
    @(negedge clk);
    check({req, " idle level"}, 32'(pin_out), 32'(init));
    check({req, " oe"}, 32'(pin_oe), 1);
    cnt_run = 1;
    repeat (4) @(negedge clk);
    check("R7 before match edge", 32'(pin_out), 32'(init));
    @(negedge clk);
    check({req, " match action"}, 32'(pin_out), 32'(fin));
    @(negedge clk);
    check({req, " after match"}, 32'(pin_out), 32'(fin));
  endtask

  task automatic t_disabled(input logic [3:0] c);
    do_reset();
    put_gr(16'd3);
    put_ctl(c);
    cnt_run = 1;
    repeat (6) @(negedge clk);
    check("R3 oe off", 32'(pin_oe), 0);
    check("R3 pin untouched", 32'(pin_out), 0);
  endtask

  task automatic t_run_init();
    do_reset();
    put_gr(16'd2);
    put_ctl(4'b0010);
    @(negedge clk);
    cnt_run = 1;
    repeat (4) @(negedge clk);
    check("R6 pin high after match", 32'(pin_out), 1);
    put_ctl(4'b0001);
    @(negedge clk);
    check("R6 no idle while running", 32'(pin_out), 1);
    cnt_run = 0;
    @(negedge clk);
    check("R6 idle when stopped", 32'(pin_out), 0);
  endtask

  task automatic pin_edge(input logic lvl, input logic expect_cap, input string req);
    logic [W-1:0] prev, rec;
    prev = gr_q;
    cap_pin = lvl;
    @(negedge clk);
    @(negedge clk);
    rec = cnt_q;
    @(negedge clk);
    check(req, 32'(gr_q), expect_cap ? 32'(rec) : 32'(prev));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_cap(input logic [3:0] c, input logic on_rise, input logic on_fall);
    do_reset();
    put_ctl(c);
    cnt_run = 1;
    repeat (3) @(negedge clk);
    pin_edge(1'b1, on_rise, "R8 rise capture");
    pin_edge(1'b0, on_fall, "R8 fall capture");
  endtask

  task automatic t_evt();
    logic [W-1:0] rec;
    do_reset();
    put_ctl(4'b1101);
    cnt_run = 1;
    repeat (3) @(negedge clk);
    pin_edge(1'b1, 1'b0, "R9 pin ignored");
    cnt_evt = 1; rec = cnt_q;
    @(negedge clk);
    cnt_evt = 0;
    check("R9 strobe capture", 32'(gr_q), 32'(rec));
  endtask

  task automatic t_priority();
    logic [W-1:0] rec;
    do_reset();
    put_ctl(4'b1100);
    cnt_run = 1;
    repeat (5) @(negedge clk);
    cnt_evt = 1; gr_we = 1; gr_wdata = 16'hABCD; rec = cnt_q;
    @(negedge clk);
    cnt_evt = 0; gr_we = 0;
    check("R11 capture wins", 32'(gr_q), 32'(rec));
    put_gr(16'h1234);
    check("R11 plain write", 32'(gr_q), 32'h1234);
  endtask

  task automatic t_buf();
    do_reset();
    buf_mode = 1;
    put_gr(16'd7);
    put_ctl(4'b1000);
    cnt_run = 1;
    pin_edge(1'b1, 1'b0, "R10 no pin capture");
    put_ctl(4'b1100);
    cnt_evt = 1;
    @(negedge clk);
    cnt_evt = 0;
    check("R10 no strobe capture", 32'(gr_q), 7);
    cnt_run = 0;
    put_ctl(4'b0110);
    repeat (2) @(negedge clk);
    check("R10 oe off", 32'(pin_oe), 0);
    check("R10 no idle level", 32'(pin_out), 0);
    put_gr(16'd3);
    check("R10 write works", 32'(gr_q), 3);
  endtask

  initial begin
    rst_n = 0;
    t_reset_ctl();
    t_count();
    t_cmp(4'b0001, 1'b0, 1'b0, "R4 low/low");
    t_cmp(4'b0010, 1'b0, 1'b1, "R4 low/high");
    t_cmp(4'b0011, 1'b0, 1'b1, "R4 low/toggle");
    t_cmp(4'b0101, 1'b1, 1'b0, "R5 high/low");
    t_cmp(4'b0110, 1'b1, 1'b1, "R5 high/high");
    t_cmp(4'b0111, 1'b1, 1'b0, "R5 high/toggle");
    t_disabled(4'b0000);
    t_disabled(4'b0100);
    t_run_init();
    t_cap(4'b1000, 1'b1, 1'b0);
    t_cap(4'b1001, 1'b0, 1'b1);
    t_cap(4'b1010, 1'b1, 1'b1);
    t_cap(4'b1011, 1'b1, 1'b1);
    t_evt();
    t_priority();
    t_buf();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule